// File: doc/BRIEF.md
# Low-Power SDRAM Power-Up and Power-Mode Sequencer

This block drives the command pins and the clock-enable of a low-power SDRAM. After reset it runs the device's initialisation. It first waits for power to settle. It then issues a precharge of all banks and two auto-refresh commands. It loads the mode register and then the extended mode register, with NOP cycles after each command. Only when this is done does it raise `ready` and let the access path through. Until then, access requests are held off with a stall. They are not dropped, because the requester keeps its request asserted until it is granted.

Three configuration bits control the power-saving modes: refresh enable, refresh mode and deep select. All three are written together. Raising the refresh-mode bit while refresh enable is already stored as 1 puts the device into one of two modes:

- If deep select is stored as 0, the device enters self-refresh and its contents are kept.
- If deep select is stored as 1, the device enters deep power-down and nothing is refreshed.

Clearing the refresh-mode bit raises CKE again. Leaving self-refresh costs one refresh-cycle wait. Leaving deep power-down forces the complete power-up sequence to run again before `ready` returns. The data bus is kept in high impedance (`dq_hiz`) whenever the block is not ready.

Top module: `lpsd_seq`

## Requirements
- R1: From reset, `sd_cke` is 1, `ready` is 0 and the command pins {cs_n,ras_n,cas_n,we_n} show NOP (4'b0111) for T_PWR cycles after reset release.
- R2: The initialisation issues these commands in this order: precharge-all (4'b0010), then T_RP NOP cycles, then auto-refresh (4'b0001), then T_RC NOP cycles, then auto-refresh, then T_RC NOP cycles. It then issues a mode-register load (4'b0000, `sd_ba`=2'b00, `sd_addr`=MRS_VAL) and T_MRD NOP cycles. Last come an extended mode-register load (4'b0000, `sd_ba`=2'b10, `sd_addr`=EMRS_VAL) and T_MRD NOP cycles.
- R3: During precharge-all, `sd_addr[10]` is 1. On all cycles other than the two mode loads, all other address bits and `sd_ba` are 0.
- R4: `ready` rises in the cycle after the last trailing NOP of the extended mode load. It stays high until a power-saving mode is entered. `dq_hiz` equals the inverse of `ready` in every cycle.
- R5: In the same cycle, `acc_stall` equals `acc_req` AND NOT `ready`, and `acc_grant` equals `acc_req` AND `ready`.
- R6: Each configuration write decides the power-mode target as follows:
  - Writing refresh-mode 0 clears the target.
  - Writing refresh-mode 1 while the stored refresh-mode is 0 selects deep power-down if the stored refresh enable and deep select are both 1. It selects self-refresh if the stored refresh enable is 1 and deep select is 0.
  - A write with stored refresh enable 0 selects nothing and has no effect on CKE or `ready`.
- R7: In `ready`, a self-refresh target produces, on the next cycle, one self-refresh command (4'b0001 with `sd_cke`=0). `sd_cke` then stays 0 with NOP until the target is cleared.
- R8: In `ready`, a deep power-down target produces, on the next cycle, one power-down command (4'b0110 with `sd_cke`=0). `sd_cke` then stays 0 with NOP until the target is cleared.
- R9: When the target is cleared in self-refresh, `sd_cke` rises on the next cycle and T_RC NOP cycles follow. `ready` then returns without any initialisation command.
- R10: When the target is cleared in deep power-down, `sd_cke` rises on the next cycle and the full R1 and R2 sequence runs again before `ready` returns.
- R11: A power-mode target written while `ready` is low is kept. It takes effect once `ready` is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rfsh_en | input | 1 | Refresh-enable bit to write |
| cfg_rmode | input | 1 | Refresh-mode bit to write |
| cfg_deep | input | 1 | Deep power-down select bit to write |
| acc_req | input | 1 | Memory access request, held until granted |
| acc_stall | output | 1 | Request present but held off |
| acc_grant | output | 1 | Request present and allowed |
| ready | output | 1 | Device initialised and in normal operation |
| dq_hiz | output | 1 | Keep the data bus in high impedance |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address (bit 1 selects the extended register) |
| sd_addr | output | ADDR_W | Address bus (bit 10 is the all-banks flag) |

## Verification
The hardest state to reach is an entry into a power mode that was requested while the sequencer was still busy. The stored bits must line up so that the raising write is decoded against the old refresh-enable and deep-select values, not the new ones. The stimulus first leaves deep power-down with a write that also clears deep select. During the re-run initialisation it then raises refresh-mode, so that self-refresh is pending when `ready` arrives. The bench also checks a single write that sets refresh enable and refresh-mode together, which must be ignored because the stored refresh enable is still 0.

// File: rtl/lpsd_pkg.sv
package lpsd_pkg;

   typedef enum logic [1:0] {
      TGT_NONE,
      TGT_SREF,
      TGT_DPD
   } tgt_e;

   typedef enum logic [3:0] {
      ST_PWR,
      ST_PALL,
      ST_TRP,
      ST_REF,
      ST_TRC,
      ST_MRS,
      ST_MRD,
      ST_EMRS,
      ST_EMRD,
      ST_READY,
      ST_SENT,
      ST_SREF,
      ST_SEXIT,
      ST_DENT,
      ST_DPD
   } st_e;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_PALL,
      CMD_REF,
      CMD_MRS,
      CMD_EMRS,
      CMD_SELF,
      CMD_DPD
   } cmd_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } pins_t;

   function automatic pins_t cmd_pins(cmd_e c);
      pins_t p;
      unique case (c)
         CMD_PALL: p = 4'b0010;
         CMD_REF,
         CMD_SELF: p = 4'b0001;
         CMD_MRS,
         CMD_EMRS: p = 4'b0000;
         CMD_DPD:  p = 4'b0110;
         default:  p = 4'b0111;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/lpsd_cfg_reg.sv
module lpsd_cfg_reg
   import lpsd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_rfsh,
   input  logic wr_rmode,
   input  logic wr_deep,
   output tgt_e tgt
);

   logic rfsh_q;
   logic rmode_q;
   logic deep_q;
   tgt_e tgt_d;

   // the raising write is decoded against the bits stored before it
   always_comb begin
      tgt_d = tgt;
      if (wr) begin
         if (!wr_rmode) begin
            tgt_d = TGT_NONE;
         end else if (!rmode_q) begin
            if (!rfsh_q)     tgt_d = TGT_NONE;
            else if (deep_q) tgt_d = TGT_DPD;
            else             tgt_d = TGT_SREF;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rfsh_q  <= 1'b0;
         rmode_q <= 1'b0;
         deep_q  <= 1'b0;
         tgt     <= TGT_NONE;
      end else begin
         tgt <= tgt_d;
         if (wr) begin
            rfsh_q  <= wr_rfsh;
            rmode_q <= wr_rmode;
            deep_q  <= wr_deep;
         end
      end
   end

   // R6
   no_rfsh_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wr_rmode && !rmode_q && !rfsh_q) |=> (tgt == TGT_NONE));

   // R6
   tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(tgt));

endmodule

// File: rtl/lpsd_wait_timer.sv
module lpsd_wait_timer #(
   parameter int CNT_W   = 3,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   if (RST_VAL >= (1 << CNT_W)) begin : g_bad_rst
      $error("lpsd_wait_timer: RST_VAL does not fit CNT_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CNT_W'(RST_VAL);
      end else if (start) begin
         cnt <= start_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

   // R2
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == $past(start_val)));

   // R2
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !done) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/lpsd_cmd_enc.sv
module lpsd_cmd_enc
   import lpsd_pkg::*;
#(
   parameter int          ADDR_W   = 13,
   parameter int          A10_BIT  = 10,
   parameter logic [ADDR_W-1:0] MRS_VAL  = '0,
   parameter logic [ADDR_W-1:0] EMRS_VAL = '0,
   parameter bit          REG_OUT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd,
   input  logic              cke_in,
   output pins_t             pins,
   output logic              cke,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << A10_BIT;

   pins_t             pins_c;
   logic [1:0]        ba_c;
   logic [ADDR_W-1:0] addr_c;

   always_comb begin
      pins_c = cmd_pins(cmd);
      ba_c   = 2'b00;
      addr_c = '0;
      unique case (cmd)
         CMD_PALL: addr_c = ALL_BANKS;
         CMD_MRS:  addr_c = MRS_VAL;
         CMD_EMRS: begin
            addr_c = EMRS_VAL;
            ba_c   = 2'b10;
         end
         default: ;
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pins <= 4'b0111;
            cke  <= 1'b1;
            ba   <= 2'b00;
            addr <= '0;
         end else begin
            pins <= pins_c;
            cke  <= cke_in;
            ba   <= ba_c;
            addr <= addr_c;
         end
      end
   end else begin : g_comb
      assign pins = pins_c;
      assign cke  = cke_in;
      assign ba   = ba_c;
      assign addr = addr_c;
   end

endmodule

// File: rtl/lpsd_seq.sv
module lpsd_seq
   import lpsd_pkg::*;
#(
   parameter int          ADDR_W   = 13,
   parameter int          T_PWR    = 4,
   parameter int          T_RP     = 2,
   parameter int          T_RC     = 2,
   parameter int          T_MRD    = 2,
   parameter logic [ADDR_W-1:0] MRS_VAL  = 13'h0032,
   parameter logic [ADDR_W-1:0] EMRS_VAL = 13'h0020,
   parameter bit          REG_OUT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_rfsh_en,
   input  logic              cfg_rmode,
   input  logic              cfg_deep,
   input  logic              acc_req,
   output logic              acc_stall,
   output logic              acc_grant,
   output logic              ready,
   output logic              dq_hiz,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [1:0]        sd_ba,
   output logic [ADDR_W-1:0] sd_addr
);

   localparam int MAX_AB = (T_PWR > T_RP)  ? T_PWR  : T_RP;
   localparam int MAX_CD = (T_RC  > T_MRD) ? T_RC   : T_MRD;
   localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W  = (MAX_T > 1) ? $clog2(MAX_T) : 1;
   localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(T_PWR - 1);
   localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP  - 1);
   localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC  - 1);
   localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

   if (ADDR_W < 11) begin : g_bad_addr
      $error("lpsd_seq: ADDR_W must hold the all-banks bit 10");
   end
   if (T_PWR < 1 || T_RP < 1 || T_RC < 1 || T_MRD < 1) begin : g_bad_wait
      $error("lpsd_seq: every wait length must be at least one cycle");
   end

   st_e              st, st_d;
   logic             ref_two, ref_two_d;
   tgt_e             tgt;
   logic             tm_start;
   logic [CNT_W-1:0] tm_val;
   logic             tm_done;
   cmd_e             cmd;
   logic             cke_c;
   pins_t            pins;

   lpsd_cfg_reg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_we),
      .wr_rfsh  (cfg_rfsh_en),
      .wr_rmode (cfg_rmode),
      .wr_deep  (cfg_deep),
      .tgt      (tgt)
   );

   lpsd_wait_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (T_PWR - 1)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (tm_start),
      .start_val (tm_val),
      .done      (tm_done)
   );

   always_comb begin
      st_d      = st;
      ref_two_d = ref_two;
      tm_start  = 1'b0;
      tm_val    = '0;
      unique case (st)
         ST_PWR: begin
            ref_two_d = 1'b0;
            if (tm_done) st_d = ST_PALL;
         end
         ST_PALL: begin
            tm_start = 1'b1;
            tm_val   = LD_RP;
            st_d     = ST_TRP;
         end
         ST_TRP:  if (tm_done) st_d = ST_REF;
         ST_REF: begin
            tm_start = 1'b1;
            tm_val   = LD_RC;
            st_d     = ST_TRC;
         end
         ST_TRC: begin
            if (tm_done) begin
               if (ref_two) begin
                  st_d = ST_MRS;
               end else begin
                  ref_two_d = 1'b1;
                  st_d      = ST_REF;
               end
            end
         end
         ST_MRS: begin
            tm_start = 1'b1;
            tm_val   = LD_MRD;
            st_d     = ST_MRD;
         end
         ST_MRD:  if (tm_done) st_d = ST_EMRS;
         ST_EMRS: begin
            tm_start = 1'b1;
            tm_val   = LD_MRD;
            st_d     = ST_EMRD;
         end
         ST_EMRD: if (tm_done) st_d = ST_READY;
         ST_READY: begin
            if (tgt == TGT_SREF)     st_d = ST_SENT;
            else if (tgt == TGT_DPD) st_d = ST_DENT;
         end
         ST_SENT: st_d = ST_SREF;
         ST_SREF: begin
            if (tgt == TGT_NONE) begin
               tm_start = 1'b1;
               tm_val   = LD_RC;
               st_d     = ST_SEXIT;
            end
         end
         ST_SEXIT: if (tm_done) st_d = ST_READY;
         ST_DENT: st_d = ST_DPD;
         ST_DPD: begin
            if (tgt == TGT_NONE) begin
               tm_start = 1'b1;
               tm_val   = LD_PWR;
               st_d     = ST_PWR;
            end
         end
         default: st_d = ST_PWR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_PWR;
         ref_two <= 1'b0;
      end else begin
         st      <= st_d;
         ref_two <= ref_two_d;
      end
   end

   always_comb begin
      unique case (st)
         ST_PALL: cmd = CMD_PALL;
         ST_REF:  cmd = CMD_REF;
         ST_MRS:  cmd = CMD_MRS;
         ST_EMRS: cmd = CMD_EMRS;
         ST_SENT: cmd = CMD_SELF;
         ST_DENT: cmd = CMD_DPD;
         default: cmd = CMD_NOP;
      endcase
   end

   assign cke_c = !(st == ST_SENT || st == ST_SREF || st == ST_DENT || st == ST_DPD);

   lpsd_cmd_enc #(
      .ADDR_W   (ADDR_W),
      .A10_BIT  (10),
      .MRS_VAL  (MRS_VAL),
      .EMRS_VAL (EMRS_VAL),
      .REG_OUT  (REG_OUT)
   ) u_enc (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .cke_in (cke_c),
      .pins   (pins),
      .cke    (sd_cke),
      .ba     (sd_ba),
      .addr   (sd_addr)
   );

   assign sd_cs_n   = pins.cs_n;
   assign sd_ras_n  = pins.ras_n;
   assign sd_cas_n  = pins.cas_n;
   assign sd_we_n   = pins.we_n;
   assign ready     = (st == ST_READY);
   assign dq_hiz    = !ready;
   assign acc_stall = acc_req && !ready;
   assign acc_grant = acc_req && ready;

   // R4
   ready_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(st) == ST_EMRD || $past(st) == ST_SEXIT));

   // R7
   cke_low_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cke |-> !ready);

   // R3
   pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010) |-> sd_addr[10]);

   // R10
   dpd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DPD && tgt == TGT_NONE) |=> (st == ST_PWR && !ready));

   // R5
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !ready) |-> (acc_stall && !acc_grant));

endmodule

// File: tb/lpsd_seq_bench.sv
`timescale 1ns/1ps
module lpsd_seq_bench;

   localparam int TPW  = 4;
   localparam int TRP  = 2;
   localparam int TRC  = 2;
   localparam int TMRD = 2;
   localparam logic [12:0] MRSV  = 13'h0032;
   localparam logic [12:0] EMRSV = 13'h0020;
   localparam logic [3:0] P_NOP  = 4'b0111;
   localparam logic [3:0] P_PALL = 4'b0010;
   localparam logic [3:0] P_REF  = 4'b0001;
   localparam logic [3:0] P_MRS  = 4'b0000;
   localparam logic [3:0] P_DPD  = 4'b0110;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_rfsh_en = 1'b0, cfg_rmode = 1'b0, cfg_deep = 1'b0;
   logic acc_req = 1'b0;
   logic acc_stall, acc_grant, ready, dq_hiz, sd_cke;
   logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [12:0] sd_addr;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   lpsd_seq #(
      .ADDR_W (13), .T_PWR (TPW), .T_RP (TRP), .T_RC (TRC), .T_MRD (TMRD),
      .MRS_VAL (MRSV), .EMRS_VAL (EMRSV), .REG_OUT (1'b0)
   ) u_lpsd_seq (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_rfsh_en (cfg_rfsh_en),
      .cfg_rmode (cfg_rmode), .cfg_deep (cfg_deep), .acc_req (acc_req),
      .acc_stall (acc_stall), .acc_grant (acc_grant), .ready (ready),
      .dq_hiz (dq_hiz), .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
      .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba), .sd_addr (sd_addr)
   );

   // reference model: queue of expected cycles
   typedef struct {
      logic [3:0]  pins;
      logic        cke;
      logic        rdy;
      logic [12:0] addr;
      logic [1:0]  ba;
      int          kind;   // 0 sequence, 1 ready, 2 self-refresh hold, 3 deep hold
      string       tag;
   } ent_t;

   ent_t exp_q[$];
   ent_t cur;
   bit   m_valid = 1'b0;
   bit   m_rfsh, m_rmode, m_deep;
   int   m_tgt;

   function automatic ent_t mk(logic [3:0] p, logic ck, logic r, logic [12:0] a,
                               logic [1:0] b, int k, string t);
      ent_t e;
      e.pins = p; e.cke = ck; e.rdy = r; e.addr = a; e.ba = b; e.kind = k; e.tag = t;
      return e;
   endfunction

   function automatic void push_init(string pwr_tag);
      for (int i = 0; i < TPW; i++) exp_q.push_back(mk(P_NOP, 1, 0, 0, 0, 0, pwr_tag));
      exp_q.push_back(mk(P_PALL, 1, 0, 13'h0400, 0, 0, "R3"));
      for (int i = 0; i < TRP; i++) exp_q.push_back(mk(P_NOP, 1, 0, 0, 0, 0, "R2"));
      for (int r = 0; r < 2; r++) begin
         exp_q.push_back(mk(P_REF, 1, 0, 0, 0, 0, "R2"));
         for (int i = 0; i < TRC; i++) exp_q.push_back(mk(P_NOP, 1, 0, 0, 0, 0, "R2"));
      end
      exp_q.push_back(mk(P_MRS, 1, 0, MRSV, 2'b00, 0, "R2"));
      for (int i = 0; i < TMRD; i++) exp_q.push_back(mk(P_NOP, 1, 0, 0, 0, 0, "R2"));
      exp_q.push_back(mk(P_MRS, 1, 0, EMRSV, 2'b10, 0, "R2"));
      for (int i = 0; i < TMRD; i++) exp_q.push_back(mk(P_NOP, 1, 0, 0, 0, 0, "R2"));
      exp_q.push_back(mk(P_NOP, 1, 1, 0, 0, 1, "R4"));
   endfunction

   always @(posedge clk) begin
      int old_tgt;
      cyc++;
      if (!rst_n) begin
         m_rfsh = 0; m_rmode = 0; m_deep = 0; m_tgt = 0;
         exp_q.delete();
         push_init("R1");
         cur = exp_q.pop_front();
         m_valid = 1'b1;
      end else if (m_valid) begin
         old_tgt = m_tgt;
         // R6 target decode against previously stored bits
         if (cfg_we) begin
            if (!cfg_rmode)   m_tgt = 0;
            else if (!m_rmode) m_tgt = m_rfsh ? (m_deep ? 2 : 1) : 0;
            m_rfsh = cfg_rfsh_en; m_rmode = cfg_rmode; m_deep = cfg_deep;
         end
         if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
         end else begin
            case (cur.kind)
               1: begin
                  if (old_tgt == 1) begin
                     cur = mk(P_REF, 0, 0, 0, 0, 0, "R7");
                     exp_q.push_back(mk(P_NOP, 0, 0, 0, 0, 2, "R7"));
                  end else if (old_tgt == 2) begin
                     cur = mk(P_DPD, 0, 0, 0, 0, 0, "R8");
                     exp_q.push_back(mk(P_NOP, 0, 0, 0, 0, 3, "R8"));
                  end
               end
               2: if (old_tgt == 0) begin
                  for (int i = 0; i < TRC; i++) exp_q.push_back(mk(P_NOP, 1, 0, 0, 0, 0, "R9"));
                  exp_q.push_back(mk(P_NOP, 1, 1, 0, 0, 1, "R9"));
                  cur = exp_q.pop_front();
               end
               3: if (old_tgt == 0) begin
                  push_init("R10");
                  cur = exp_q.pop_front();
               end
               default: ;
            endcase
         end
      end
   end

   task automatic check(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, expv, cyc);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && m_valid) begin
         check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == cur.pins, cur.tag, "cmd pins",
               {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, cur.pins);
         check(sd_cke == cur.cke, cur.tag, "cke", sd_cke, cur.cke);
         check(sd_addr == cur.addr && sd_ba == cur.ba, cur.tag, "addr/ba",
               {sd_ba, sd_addr}, {cur.ba, cur.addr});
         check(ready == cur.rdy && dq_hiz == !cur.rdy, "R4", "ready/dq_hiz",
               {ready, dq_hiz}, {cur.rdy, !cur.rdy});
         check(acc_stall == (acc_req && !cur.rdy) && acc_grant == (acc_req && cur.rdy),
               "R5", "stall/grant", {acc_stall, acc_grant},
               {acc_req && !cur.rdy, acc_req && cur.rdy});
      end
   end

   // request pattern, changed just after each edge
   initial begin
      forever begin
         @(posedge clk); #1;
         acc_req = (cyc % 3) != 0;
      end
   end

   task automatic wr(bit rf, bit rm, bit dp);
      @(posedge clk); #1;
      cfg_we = 1; cfg_rfsh_en = rf; cfg_rmode = rm; cfg_deep = dp;
      @(posedge clk); #1;
      cfg_we = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 0;
      @(negedge clk);
      // R1 reset state
      check(ready == 0 && sd_cke == 1, "R1", "reset ready/cke", {ready, sd_cke}, 2'b01);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == P_NOP, "R1", "reset pins",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, P_NOP);
      idle(2); #1;
      rst_n = 1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      idle(25);                // R2 full init then ready
      wr(1, 1, 0);             // R6 stored refresh enable is 0: ignored
      idle(6);
      check(sd_cke == 1 && ready == 1, "R6", "ignored write", {sd_cke, ready}, 2'b11);
      wr(1, 0, 0);
      wr(1, 1, 0);             // R7 self-refresh
      idle(8);
      check(sd_cke == 0, "R7", "in self-refresh", sd_cke, 0);
      wr(1, 0, 0);             // R9 exit
      idle(6);
      check(ready == 1, "R9", "back to ready", ready, 1);
      wr(1, 0, 1);
      wr(1, 1, 1);             // R8 deep power-down
      idle(8);
      check(sd_cke == 0, "R8", "in deep power-down", sd_cke, 0);
      wr(1, 0, 0);             // R10 exit, deep select cleared in same write
      idle(4);
      check(ready == 0 && sd_cke == 1, "R10", "re-init running", {ready, sd_cke}, 2'b01);
      wr(1, 1, 0);             // R11 self-refresh requested during re-init
      check(ready == 0 && sd_cke == 1, "R11", "still initialising", {ready, sd_cke}, 2'b01);
      idle(30);
      check(sd_cke == 0 && ready == 0, "R11", "deferred entry taken", {sd_cke, ready}, 2'b00);
      wr(1, 0, 0);
      idle(6);
      do_reset();              // R1 reset from mid-operation
      idle(25);
      check(ready == 1, "R4", "ready after second reset", ready, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule